// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh

The controller connects a simple synchronous host port to an asynchronous DRAM device. The device has a multiplexed address bus and active-low strobes. For each host request, the controller splits the flat word address into a row part and a column part. It presents the row on the shared address lines and latches it with a falling RAS. It then presents the column and latches it with a falling CAS. A read returns its data on the host side with a single-cycle ready pulse.

After an access, the row stays open, with RAS held low. A later request to the same row reuses the open row and only pulses CAS. A request to a different row first closes the open row, waits out the precharge time, and then opens the new row. An interval counter raises a refresh request. At the next idle point the controller closes any open row. It then runs a CAS-before-RAS refresh, which needs no address. No host access is serviced until the refresh has finished. All device timings are elaboration parameters counted in clock cycles.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held, and right after it, RAS, CAS and chip enable are high (inactive) and ready_o is low.
- R2: The row part of the address is `addr_i[ADDR_W-1:COL_W]` and the column part is `addr_i[COL_W-1:0]`. The row is on the address lines when RAS falls, and the column is there when CAS falls. A column strobe in an access follows the RAS fall by at least T_RCD cycles.
- R3: Chip enable is low whenever RAS or CAS is low. When CAS falls, read/write is low for a write and high for a read. The data-out enable is high exactly for writes.
- R4: A request to the row that is currently open causes no new RAS fall. Its ready pulse arrives T_CAS+1 cycles after the request is sampled.
- R5: Before any RAS fall, RAS has been high for at least T_RP cycles. A request to a different row than the open one takes T_RP+T_RCD+T_CAS+1 cycles. A request made while no row is open takes T_RCD+T_CAS+1 cycles.
- R6: Every access CAS pulse lasts exactly T_CAS cycles.
- R7: A read returns the word most recently written to that address. ready_o is a single-cycle pulse.
- R8: A refresh asserts CAS at least one cycle before RAS. Refresh cycles recur at least once every REF_INTERVAL+16 cycles.
- R9: ready_o stays low while a refresh strobe is active. RAS has been high for at least T_RP cycles before a refresh CAS falls, so any open row is closed first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ROW_W+COL_W | Word address (row in upper bits) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with ready_o |
| ready_o | output | 1 | One-cycle completion pulse |
| dram_ce_no | output | 1 | Device chip enable, active low |
| dram_rw_no | output | 1 | Read/write, low = write |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_o | output | DATA_W | Data to device |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | DATA_W | Data from device |

## Verification
The bench sweeps every address of a 64-word configuration in several orders:
- A row-major write then read is almost all page hits. It separates reuse of the open row from needless reopening.
- A column-major read turns every access into a row change. It exposes a missing precharge or a wrong row/column split, because each word carries a distinct value.
- A pass over the rows in descending order with fresh data, followed by an alternating two-row read, catches stale data and page-tracking mistakes.
- Long idle gaps force refreshes while a row is open. They show whether the page is closed first, whether CAS leads RAS, and whether ready stays low throughout.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_PRE,
    S_ROW,
    S_COL,
    S_DONE,
    S_REF_PRE,
    S_REF_CAS,
    S_REF_RAS,
    S_REF_END
  } ctrl_state_e;
endpackage

// File: rtl/dram_wait_timer.sv
module dram_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_count_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CW = $clog2(INTERVAL);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end

  p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !ack_i) |=> pend_o);
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_page_pkg::*;
#(
  parameter int ROW_W        = 8,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_REF_RAS    = 3,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      req_i,
  input  logic                                      we_i,
  input  logic [ROW_W+COL_W-1:0]                    addr_i,
  input  logic [DATA_W-1:0]                         wdata_i,
  output logic [DATA_W-1:0]                         rdata_o,
  output logic                                      ready_o,
  output logic                                      dram_ce_no,
  output logic                                      dram_rw_no,
  output logic                                      dram_ras_no,
  output logic                                      dram_cas_no,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
  output logic [DATA_W-1:0]                         dram_dq_o,
  output logic                                      dram_dq_oe_o,
  input  logic [DATA_W-1:0]                         dram_dq_i
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_MAX1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int T_MAX2 = (T_RP > T_REF_RAS) ? T_RP : T_REF_RAS;
  localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
  localparam int WT_W   = $clog2(T_MAX + 1);
  localparam int RH_W   = $clog2(T_RP + 2);
  localparam int CL_W   = $clog2(T_CAS + 2);

  ctrl_state_e       state_q, state_d;
  logic              page_open_q;
  logic [ROW_W-1:0]  open_row_q, row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wt_load, wt_done, ref_pend, ref_ack, accept;
  logic [WT_W-1:0]   wt_val;
  logic [ROW_W-1:0]  req_row;

  assign req_row = addr_i[ADDR_W-1:COL_W];
  assign accept  = (state_q == S_IDLE) && !ref_pend && req_i;

  dram_wait_timer #(.CNT_W(WT_W)) u_wait (
    .clk_i, .rst_ni, .load_i(wt_load), .load_val_i(wt_val), .expired_o(wt_done)
  );

  dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i, .rst_ni, .ack_i(ref_ack), .pend_o(ref_pend)
  );

  always_comb begin
    state_d = state_q;
    wt_load = 1'b0;
    wt_val  = '0;
    ref_ack = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_pend) begin
          if (page_open_q) begin
            state_d = S_REF_PRE; wt_load = 1'b1; wt_val = WT_W'(T_RP - 1);
          end else begin
            state_d = S_REF_CAS; ref_ack = 1'b1;
          end
        end else if (req_i) begin
          if (page_open_q && req_row == open_row_q) begin
            state_d = S_COL; wt_load = 1'b1; wt_val = WT_W'(T_CAS - 1);
          end else if (page_open_q) begin
            state_d = S_PRE; wt_load = 1'b1; wt_val = WT_W'(T_RP - 1);
          end else begin
            state_d = S_ROW; wt_load = 1'b1; wt_val = WT_W'(T_RCD - 1);
          end
        end
      end
      S_PRE: if (wt_done) begin
        state_d = S_ROW; wt_load = 1'b1; wt_val = WT_W'(T_RCD - 1);
      end
      S_ROW: if (wt_done) begin
        state_d = S_COL; wt_load = 1'b1; wt_val = WT_W'(T_CAS - 1);
      end
      S_COL:     if (wt_done) state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      S_REF_PRE: if (wt_done) begin
        state_d = S_REF_CAS; ref_ack = 1'b1;
      end
      S_REF_CAS: begin
        state_d = S_REF_RAS; wt_load = 1'b1; wt_val = WT_W'(T_REF_RAS - 1);
      end
      S_REF_RAS: if (wt_done) begin
        state_d = S_REF_END; wt_load = 1'b1; wt_val = WT_W'(T_RP - 1);
      end
      S_REF_END: if (wt_done) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      page_open_q <= 1'b0;
      open_row_q  <= '0;
      row_q       <= '0;
      col_q       <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      rdata_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        row_q   <= req_row;
        col_q   <= addr_i[COL_W-1:0];
        we_q    <= we_i;
        wdata_q <= wdata_i;
      end
      if (state_q == S_ROW) begin
        page_open_q <= 1'b1;
        open_row_q  <= row_q;
      end else if (state_d == S_PRE || state_d == S_REF_PRE) begin
        page_open_q <= 1'b0;
      end
      // sample device data at the last CAS-active cycle
      if (state_q == S_COL && wt_done && !we_q) rdata_q <= dram_dq_i;
    end
  end

  always_comb begin
    dram_ras_no  = 1'b1;
    dram_cas_no  = 1'b1;
    dram_rw_no   = 1'b1;
    dram_dq_oe_o = 1'b0;
    dram_addr_o  = '0;
    unique case (state_q)
      S_IDLE: dram_ras_no = !page_open_q;
      S_ROW: begin
        dram_ras_no = 1'b0; dram_addr_o = MUX_W'(row_q);
      end
      S_COL: begin
        dram_ras_no  = 1'b0;
        dram_cas_no  = 1'b0;
        dram_addr_o  = MUX_W'(col_q);
        dram_rw_no   = !we_q;
        dram_dq_oe_o = we_q;
      end
      S_DONE: begin
        dram_ras_no = 1'b0; dram_addr_o = MUX_W'(col_q);
      end
      S_REF_CAS: dram_cas_no = 1'b0;
      S_REF_RAS: begin
        dram_ras_no = 1'b0; dram_cas_no = 1'b0;
      end
      default: ;
    endcase
  end

  assign dram_ce_no = dram_ras_no & dram_cas_no;
  assign dram_dq_o  = wdata_q;
  assign ready_o    = (state_q == S_DONE);
  assign rdata_o    = rdata_q;

  // strobe run-length trackers for the timing checks
  logic [RH_W-1:0] ras_hi_cnt;
  logic [CL_W-1:0] cas_lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_hi_cnt <= RH_W'(T_RP);
      cas_lo_cnt <= '0;
    end else begin
      if (!dram_ras_no)                ras_hi_cnt <= '0;
      else if (ras_hi_cnt < RH_W'(T_RP)) ras_hi_cnt <= ras_hi_cnt + 1'b1;
      if (dram_cas_no)                 cas_lo_cnt <= '0;
      else if (cas_lo_cnt < CL_W'(T_CAS + 1)) cas_lo_cnt <= cas_lo_cnt + 1'b1;
    end
  end

  p_precharge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> (ras_hi_cnt >= RH_W'(T_RP)));
  p_cas_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dram_cas_no) && !dram_ras_no) |-> (cas_lo_cnt == CL_W'(T_CAS)));
  p_ready_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  p_cas_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_ras_no) && !dram_cas_no) |-> $past(!dram_cas_no));
  p_lockout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_cas_no && (dram_ras_no || $past(dram_ras_no) || !page_open_q)) |-> !ready_o);
  p_strobe_ce_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_ras_no || !dram_cas_no) |-> !dram_ce_no);
endmodule

// File: tb/dram_page_ctrl_test.sv
module dram_page_ctrl_test;
  localparam int ROW_W = 3, COL_W = 3, DATA_W = 8;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_REF_RAS = 3, REF_INTERVAL = 150;
  localparam int ADDR_W = ROW_W + COL_W, WORDS = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata, dq_o, dq_i;
  logic ready, ce_n, rw_n, ras_n, cas_n, oe;
  logic [COL_W-1:0] maddr;

  always #2.5 clk = ~clk;

  dram_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_RP(T_RP), .T_REF_RAS(T_REF_RAS), .REF_INTERVAL(REF_INTERVAL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ready_o(ready), .dram_ce_no(ce_n), .dram_rw_no(rw_n),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_addr_o(maddr), .dram_dq_o(dq_o),
    .dram_dq_oe_o(oe), .dram_dq_i(dq_i));

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // device model and strobe monitor
  logic [DATA_W-1:0] mem [WORDS];
  logic [ROW_W-1:0] m_row = '0;
  logic [COL_W-1:0] m_col = '0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_ready = 1'b0, ref_flag = 1'b0, cur_we = 1'b0;
  int cyc = 0, ras_hi_run = 100, since_ras = 0, cas_lo_run = 0;
  int act_cnt = 0, ref_cnt = 0, last_ref = -1, last_ref_end = -100, gap_max = 0;
  int rp_bad = 0, rcd_bad = 0, rw_bad = 0, width_bad = 0, cbr_bad = 0;
  int lock_bad = 0, pulse_bad = 0, ce_bad = 0, ref_rp_bad = 0;

  assign dq_i = mem[{m_row, maddr}];

  always @(negedge clk) begin
    cyc++;
    if (prev_ras && !ras_n) begin
      if (!cas_n) begin
        if (prev_cas) cbr_bad++;
        ref_cnt++;
        if (last_ref >= 0 && cyc - last_ref > gap_max) gap_max = cyc - last_ref;
        last_ref = cyc;
      end else begin
        act_cnt++;
        m_row = maddr[ROW_W-1:0];
        if (ras_hi_run < T_RP) rp_bad++;
      end
    end
    if (prev_cas && !cas_n) begin
      if (ras_n) begin
        ref_flag = 1'b1;
        if (ras_hi_run < T_RP) ref_rp_bad++;
      end else begin
        m_col = maddr;
        if (since_ras < T_RCD) rcd_bad++;
        if (rw_n != !cur_we || oe != cur_we) rw_bad++;
        if (!rw_n) mem[{m_row, maddr}] = dq_o;
      end
    end
    if (!prev_cas && cas_n) begin
      if (ref_flag) begin
        ref_flag = 1'b0;
        last_ref_end = cyc;
      end else if (cas_lo_run != T_CAS) width_bad++;
    end
    if (ready && prev_ready) pulse_bad++;
    if (ready && ref_flag) lock_bad++;
    if ((!ras_n || !cas_n) && ce_n) ce_bad++;
    ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
    since_ras  = ras_n ? 0 : since_ras + 1;
    cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
    prev_ras = ras_n; prev_cas = cas_n; prev_ready = ready;
  end

  logic [DATA_W-1:0] gold [WORDS];
  bit hung = 0;

  task automatic access(input logic w, input int a, input logic [DATA_W-1:0] d,
                        output logic [DATA_W-1:0] rd);
    int lat = 0, r0, a0, exp_lat, exp_act;
    bit open0, quiet;
    logic [ROW_W-1:0] row0;
    @(negedge clk);
    #1;
    open0 = !ras_n; row0 = m_row; r0 = ref_cnt; a0 = act_cnt;
    quiet = !ref_flag && (cyc - last_ref_end > T_RP + 1);
    cur_we = w; we = w; addr = ADDR_W'(a); wdata = d; req = 1'b1;
    do begin @(negedge clk); #1; lat++; end while (!ready && lat < 200);
    if (lat >= 200) begin hung = 1; chk(0, "watchdog", lat, 0); end
    rd = rdata; req = 1'b0;
    chk(m_row == ROW_W'(a >> COL_W), "R2 row latched", int'(m_row), a >> COL_W);
    chk(m_col == COL_W'(a), "R2 column latched", int'(m_col), a % (1 << COL_W));
    if (ref_cnt == r0 && quiet) begin
      if (open0 && row0 == ROW_W'(a >> COL_W)) begin
        exp_lat = T_CAS + 1; exp_act = 0;
        chk(lat == exp_lat, "R4 page-hit latency", lat, exp_lat);
        chk(act_cnt - a0 == exp_act, "R4 no reactivation", act_cnt - a0, exp_act);
      end else begin
        exp_lat = open0 ? T_RP + T_RCD + T_CAS + 1 : T_RCD + T_CAS + 1;
        chk(lat == exp_lat, "R5 row-change latency", lat, exp_lat);
        chk(act_cnt - a0 == 1, "R5 one activation", act_cnt - a0, 1);
      end
    end
  endtask

  task automatic rd_chk(input int a, input string tag);
    logic [DATA_W-1:0] v;
    access(1'b0, a, '0, v);
    chk(v == gold[a], tag, int'(v), int'(gold[a]));
  endtask

  initial begin
    logic [DATA_W-1:0] dummy;
    int r0;
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && ce_n && !ready, "R1 strobes idle in reset", {ras_n, cas_n, ce_n, ready}, 14);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && ce_n && !ready, "R1 strobes idle after reset", {ras_n, cas_n, ce_n, ready}, 14);

    for (int a = 0; a < WORDS; a++) begin
      gold[a] = DATA_W'(a * 37 + 11);
      access(1'b1, a, gold[a], dummy);
    end
    for (int a = 0; a < WORDS; a++) rd_chk(a, "R7 row-major read");
    for (int c = 0; c < (1 << COL_W); c++)
      for (int r = 0; r < (1 << ROW_W); r++) rd_chk(r * (1 << COL_W) + c, "R7 column-major read");
    for (int a = WORDS - 1; a >= 0; a--) begin
      gold[a] = DATA_W'(a * 91 + 5);
      access(1'b1, a, gold[a], dummy);
    end
    for (int i = 0; i < WORDS; i++)
      rd_chk((i % 2) * (WORDS / 2) + i / 2, "R7 alternating-row read");

    // refresh with a row left open, then after idle
    access(1'b0, 9, '0, dummy);
    r0 = ref_cnt;
    repeat (3 * REF_INTERVAL + 20) @(negedge clk);
    chk(ref_cnt - r0 >= 3, "R8 refreshes during idle", ref_cnt - r0, 3);
    chk(ras_n, "R9 page closed by refresh", int'(ras_n), 1);
    rd_chk(9, "R7 read after refresh");
    rd_chk(17, "R7 read after refresh");

    chk(rp_bad == 0, "R5 precharge before activation", rp_bad, 0);
    chk(rcd_bad == 0, "R2 RAS-to-CAS delay", rcd_bad, 0);
    chk(rw_bad == 0, "R3 read/write and data enable", rw_bad, 0);
    chk(ce_bad == 0, "R3 chip enable with strobes", ce_bad, 0);
    chk(width_bad == 0, "R6 CAS pulse width", width_bad, 0);
    chk(pulse_bad == 0, "R7 ready single pulse", pulse_bad, 0);
    chk(cbr_bad == 0, "R8 CAS before RAS", cbr_bad, 0);
    chk(gap_max <= REF_INTERVAL + 16 && ref_cnt > 0, "R8 refresh gap", gap_max, REF_INTERVAL + 16);
    chk(lock_bad == 0, "R9 no ready in refresh", lock_bad, 0);
    chk(ref_rp_bad == 0, "R9 page closed before refresh", ref_rp_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule